// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache. It sits between a CPU load/store port and a slower memory port that moves one 32-bit word per handshake. Each CPU word address is split into a tag, a line index and an in-block offset, so only one line can hold that address. Each line has a valid bit, a stored tag and a four-word block. A read that hits returns its word in the same cycle. Any miss stalls the CPU while the whole block is fetched from memory. The access then starts again and completes as a hit.

Every store is written through to memory. A store that misses first brings its block into the cache, and the stored word is then merged into that block. The CPU keeps its request, address and write data steady until the done pulse. The memory side keeps its request and address steady until memory answers with ready.

Top module: `dm_cache`

## Requirements
- R1: With default parameters, the address tag is bits 31:14, the line index is bits 13:4, bits 3:2 select the word within the block, and bits 1:0 are ignored for both reads and writes.
- R2: Reset clears every valid bit, so the first access to any line after reset is a miss.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. A read hit completes in the cycle it is presented: done high, stall low, and no memory request.
- R4: A miss fetches the block as four memory reads at block-aligned word addresses, in order offset 0x0, 0x4, 0x8, 0xC. The access then completes with the requested word taken from the fetched block.
- R5: A miss whose line is valid but holds another tag drops the old block, and the new tag and block replace it. A later access with the old tag misses again. Other lines are not disturbed.
- R6: While a request has not completed, cpu_stall is high. It is high from the cycle the miss is seen until the done cycle.
- R7: A write hit sends one memory write with mem_we=1, the word-aligned address and the CPU data. It completes on mem_ready, and a later read of that word hits and returns the new data.
- R8: A write miss first fetches the whole block and then writes the word. Afterwards the written word reads back as the new data, the other words read back as memory contents, and memory also holds the new word.
- R9: The word offset selects the word within the block. Offset 0x0 is the first word, 0x4 the second and 0xC the fourth.
- R10: Once mem_req is raised, it stays high with the same mem_addr and mem_we until a cycle with mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when cpu_done and cpu_we=0 |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Request pending and not completing |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory transfer completes this cycle |

## Verification
Some internal faults show up as extra memory traffic. A valid bit that is wrongly set or cleared, or a bad tag comparison, makes a hit fetch a block or makes a miss finish with no reads, and this is visible on the first access to that line. A block word that is corrupted or written into the wrong slot only appears when that word is next read, so each fill and each store is followed by reads of neighbouring offsets and of a conflicting tag. A fault in the write-through path shows up on the memory write port in the same done cycle. A lost write is only seen when the line is evicted and the word is fetched again.

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 10,
  parameter int WORDS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = WSEL_W + BOFF_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W;
  localparam int LINES  = 1 << INDEX_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WRITE} state_t;

  state_t             state_q;
  logic [WSEL_W-1:0]  beat_q;
  logic [LINES-1:0]   valid_q;
  logic [TAG_W-1:0]   tag_mem  [LINES];
  logic [LINE_W-1:0]  data_mem [LINES];

  wire [TAG_W-1:0]   a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [INDEX_W-1:0] a_idx  = cpu_addr[OFF_W +: INDEX_W];
  wire [WSEL_W-1:0]  a_wsel = cpu_addr[BOFF_W +: WSEL_W];
  wire [LINE_W-1:0]  line   = data_mem[a_idx];
  wire               hit    = valid_q[a_idx] && (tag_mem[a_idx] == a_tag);

  wire idle_rd_hit = (state_q == S_IDLE) && cpu_req && hit && !cpu_we;
  wire fill_beat   = (state_q == S_FILL) && mem_ready;
  wire wr_finish   = (state_q == S_WRITE) && mem_ready;

  assign cpu_rdata = line[a_wsel*DATA_W +: DATA_W];
  assign cpu_done  = idle_rd_hit || wr_finish;
  assign cpu_stall = cpu_req && !cpu_done;

  assign mem_req   = (state_q != S_IDLE);
  assign mem_we    = (state_q == S_WRITE);
  assign mem_wdata = cpu_wdata;
  assign mem_addr  = (state_q == S_WRITE)
                   ? {cpu_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}}
                   : {cpu_addr[ADDR_W-1:OFF_W], beat_q, {BOFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      valid_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE:
          if (cpu_req && !idle_rd_hit) begin
            if (hit) begin
              state_q <= S_WRITE;
            end else begin
              state_q        <= S_FILL;
              beat_q         <= '0;
              valid_q[a_idx] <= 1'b0;
            end
          end
        S_FILL:
          if (mem_ready) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) begin
              valid_q[a_idx] <= 1'b1;
              state_q        <= S_IDLE;
            end
          end
        S_WRITE:
          if (mem_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if ((state_q == S_IDLE) && cpu_req && !hit)
      tag_mem[a_idx] <= a_tag;
    if (fill_beat)
      data_mem[a_idx][beat_q*DATA_W +: DATA_W] <= mem_rdata;
    else if (wr_finish)
      data_mem[a_idx][a_wsel*DATA_W +: DATA_W] <= cpu_wdata;
  end

  AST_RD_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && !cpu_we |-> !mem_req); // R3

  AST_FILL_SAME_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]); // R4

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_beat && beat_q == LAST_BEAT && cpu_req |=> hit); // R4

  AST_STALL_WHILE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && mem_req && !mem_we |-> cpu_stall); // R6

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cpu_we |-> mem_req && mem_we && mem_ready && mem_wdata == cpu_wdata
      && mem_addr[ADDR_W-1:BOFF_W] == cpu_addr[ADDR_W-1:BOFF_W]); // R7

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
endmodule

// File: tb/dm_cache_test.sv
`timescale 1ns/1ps
module dm_cache_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_done, cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  dm_cache uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] wlog_a [64];
  logic [31:0] wlog_d [64];
  int wr_n = 0;
  logic [31:0] rd_a [64];
  int rd_n = 0;

  function automatic logic [31:0] base_val(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    logic [31:0] v = base_val(a);
    for (int i = 0; i < wr_n && i < 64; i++)
      if (wlog_a[i] == a) v = wlog_d[i];
    return v;
  endfunction

  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt >= (rd_n % 3)) begin
          mem_ready = 1'b1;
          if (mem_we) begin
            if (wr_n < 64) begin
              wlog_a[wr_n] = mem_addr;
              wlog_d[wr_n] = mem_wdata;
            end
            wr_n++;
          end else begin
            mem_rdata = mem_val(mem_addr);
            if (rd_n < 64) rd_a[rd_n] = mem_addr;
            rd_n++;
          end
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] q, output int waits, output bit stalled);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    waits = 0; stalled = 1'b0; q = '0;
    forever begin
      #0.5;
      if (cpu_done) begin
        q = cpu_rdata;
        break;
      end
      stalled |= cpu_stall;
      waits++;
      if (waits > 200) begin
        check(1'b0, "R6 access hung", 32'(waits), 32'd200);
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic rd_expect(input logic [31:0] a, input logic [31:0] exp, input bit exp_miss, input string req);
    logic [31:0] q; int w; bit st; int r0;
    r0 = rd_n;
    access(1'b0, a, '0, q, w, st);
    check(q == exp, req, q, exp);
    if (exp_miss) begin
      check(rd_n - r0 == 4 && st, {req, " miss fetches 4 with stall"}, 32'(rd_n - r0), 32'd4);
    end else begin
      check(rd_n == r0 && w == 0, {req, " hit no traffic"}, 32'(w), 32'd0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!cpu_stall && !mem_req && !cpu_done, "R2 idle after reset",
          {29'd0, cpu_stall, mem_req, cpu_done}, 32'd0);
  endtask

  task automatic t_cold_miss();
    int r0 = rd_n;
    rd_expect(32'h14, base_val(32'h14), 1'b1, "R2 R4 R6 cold read 0x14");
    for (int i = 0; i < 4; i++)
      check(rd_a[r0+i] == 32'h10 + 32'(i*4), "R4 R10 fill order", rd_a[r0+i], 32'h10 + 32'(i*4));
  endtask

  task automatic t_hits();
    rd_expect(32'h1C, base_val(32'h1C), 1'b0, "R3 R9 fourth word hit");
    rd_expect(32'h10, base_val(32'h10), 1'b0, "R9 first word hit");
    rd_expect(32'h1F, base_val(32'h1C), 1'b0, "R1 low bits ignored");
  endtask

  task automatic t_second_index();
    rd_expect(32'h34, base_val(32'h34), 1'b1, "R1 index 3 miss");
    rd_expect(32'h30, base_val(32'h30), 1'b0, "R1 index 3 hit");
  endtask

  task automatic t_conflict();
    rd_expect(32'h8014, base_val(32'h8014), 1'b1, "R5 conflict replaces");
    rd_expect(32'h8018, base_val(32'h8018), 1'b0, "R5 new tag hits");
    rd_expect(32'h14, base_val(32'h14), 1'b1, "R5 old tag misses again");
    rd_expect(32'h34, base_val(32'h34), 1'b0, "R5 other line kept");
  endtask

  task automatic t_write_hit();
    logic [31:0] q; int w; bit st; int r0, w0;
    r0 = rd_n; w0 = wr_n;
    access(1'b1, 32'h1B, 32'hDEAD_BEEF, q, w, st);
    check(wr_n == w0 + 1 && rd_n == r0, "R7 one write no fill", 32'(wr_n - w0), 32'd1);
    check(wlog_a[w0] == 32'h18, "R7 R1 write address", wlog_a[w0], 32'h18);
    check(wlog_d[w0] == 32'hDEAD_BEEF, "R7 write data", wlog_d[w0], 32'hDEAD_BEEF);
    check(st, "R6 stall during write", 32'(st), 32'd1);
    rd_expect(32'h18, 32'hDEAD_BEEF, 1'b0, "R7 cached word updated");
    rd_expect(32'h14, base_val(32'h14), 1'b0, "R7 neighbour word intact");
  endtask

  task automatic t_write_miss();
    logic [31:0] q; int w; bit st; int r0, w0;
    r0 = rd_n; w0 = wr_n;
    access(1'b1, 32'h8018, 32'hCAFE_F00D, q, w, st);
    check(rd_n == r0 + 4, "R8 write miss fetches block", 32'(rd_n - r0), 32'd4);
    check(wr_n == w0 + 1 && wlog_a[w0] == 32'h8018, "R8 write forwarded", wlog_a[w0], 32'h8018);
    rd_expect(32'h8018, 32'hCAFE_F00D, 1'b0, "R8 merged word");
    rd_expect(32'h801C, base_val(32'h801C), 1'b0, "R8 fetched neighbour");
    rd_expect(32'h8010, base_val(32'h8010), 1'b0, "R8 R9 first word");
    rd_expect(32'h18, 32'hDEAD_BEEF, 1'b1, "R7 write reached memory");
  endtask

  task automatic t_top_index();
    rd_expect(32'h3FFC, base_val(32'h3FFC), 1'b1, "R1 last index miss");
    check(rd_a[rd_n-4] == 32'h3FF0, "R4 last index aligned", rd_a[rd_n-4], 32'h3FF0);
    rd_expect(32'h3FF4, base_val(32'h3FF4), 1'b0, "R9 second word hit");
    rd_expect(32'h7FFC, base_val(32'h7FFC), 1'b1, "R1 tag bit 14 differs");
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cold_miss();
    t_hits();
    t_second_index();
    t_conflict();
    t_write_hit();
    t_write_miss();
    t_top_index();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule